// File: doc/BRIEF.md
# Memory-Device Identify Responder

This block answers the identify request of a memory device's command mailbox. A one-cycle start pulse hands it a two-byte opcode (command set and command), the length of the input payload, and the device capacity in bytes. For the identify opcode with an empty input payload and a capacity that is a whole number of 256 MiB units, the block streams a packed 67-byte (0x43) response into an external payload buffer. It writes one byte per cycle, then pulses done with a success code and the response length. Every other case ends with a done pulse and an error code, and no byte is written.

The response describes persistent memory only. Two capacity fields carry the capacity in 256 MiB units: the total at byte offset 0x10 and the persistent amount at offset 0x20. A 16-byte firmware revision string, taken from a parameter, fills offsets 0x00 to 0x0F. Every other byte is zero, including the volatile capacity at offset 0x18. Multi-byte fields are little-endian. The capacity is latched when a command is accepted, so the input may change while the response is being written.

Top module: `idmb_identify_responder`

## Requirements
- R1: After reset, cmd_done and pay_we are low, and cmd_rc and rsp_len are zero.
- R2: A start with command set 0x40, command 0x00, input length 0 and a capacity whose low 28 bits are zero completes with cmd_rc = 0x0000 and rsp_len = 0x0043.
- R3: On success, pay_we is high for exactly 67 consecutive cycles, with pay_addr going 0, 1, ..., 66. The first byte is on the port two cycles after the cycle in which start is high.
- R4: On success, cmd_done is high for one cycle, in the cycle after the one that carries byte 66. cmd_rc and rsp_len are valid in that cycle.
- R5: Payload bytes 0..15 hold the firmware revision string, with byte i taken from bits [8i+7:8i] of the parameter. Bytes 0x10..0x17 and bytes 0x20..0x27 each hold capacity / 2^28 as a little-endian 64-bit value. All other bytes (0x18..0x1F, 0x28..0x42) are 0x00.
- R6: An identify start whose capacity has any of its low 28 bits set returns cmd_rc = 0x0002 and rsp_len = 0, writes no byte, and pulses cmd_done in the cycle after start.
- R7: Any opcode other than set 0x40 / command 0x00 returns cmd_rc = 0x0015, writes no byte, and pulses cmd_done in the cycle after start.
- R8: An identify start with a non-zero input length returns cmd_rc = 0x0016, writes no byte, and pulses cmd_done in the cycle after start.
- R9: When several errors apply, the reported code follows the priority 0x0015, then 0x0016, then 0x0002.
- R10: A start is ignored from the cycle after an accepted identify start up to and including the cycle that carries byte 66. Such a start produces no extra done pulse and no extra byte.
- R11: The capacity is sampled in the cycle of the accepted start. Later changes to the capacity input do not alter the bytes being written.
- R12: cmd_rc and rsp_len keep their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle command start pulse |
| cmd_set | input | 8 | Command set byte of the opcode |
| cmd_op | input | 8 | Command byte of the opcode |
| cmd_in_len | input | 16 | Input payload length in bytes |
| dev_capacity | input | 64 | Device capacity in bytes |
| pay_we | output | 1 | Payload buffer write strobe |
| pay_addr | output | 8 | Payload buffer byte address |
| pay_data | output | 8 | Payload byte |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_rc | output | 16 | Return code |
| rsp_len | output | 16 | Response length in bytes |

## Verification
The hardest case to reach from the ports is a start that arrives while a response is still streaming. This includes the exact cycle that carries the final byte, where the write strobe is still set and a careless idle test would accept a new command. The busy scenario pulses start twice while a response is streaming. The first pulse comes mid-stream, with a bad opcode and an unaligned capacity driven at the same time. The second comes in the cycle that carries the last byte. The bench then confirms a single done pulse, 67 writes, and a payload built from the capacity latched when the first command was accepted.

// File: rtl/idmb_pkg.sv
package idmb_pkg;

  localparam logic [7:0] SET_IDENTIFY = 8'h40;
  localparam logic [7:0] OP_MEMDEV    = 8'h00;
  localparam logic [15:0] EXP_IN_LEN  = 16'd0;

  localparam int RSP_BYTES = 67;

  localparam logic [15:0] RC_OK          = 16'h0000;
  localparam logic [15:0] RC_INTERNAL    = 16'h0002;
  localparam logic [15:0] RC_UNSUPPORTED = 16'h0015;
  localparam logic [15:0] RC_BAD_LEN     = 16'h0016;

  localparam int OFS_FWREV    = 0;
  localparam int FWREV_BYTES  = 16;
  localparam int OFS_TOTAL    = 16;
  localparam int OFS_VOLATILE = 24;
  localparam int OFS_PERSIST  = 32;
  localparam int CAP_FIELD_BYTES = 8;

  typedef enum logic {
    ST_IDLE,
    ST_STREAM
  } seq_state_e;

endpackage

// File: rtl/idmb_cmd_decode.sv
module idmb_cmd_decode
  import idmb_pkg::*;
#(
  parameter int CAP_W      = 64,
  parameter int UNIT_SHIFT = 28
) (
  input  logic [7:0]       set_i,
  input  logic [7:0]       op_i,
  input  logic [15:0]      in_len_i,
  input  logic [CAP_W-1:0] cap_i,
  output logic [15:0]      status_o
);

  logic opcode_hit;
  logic len_bad;
  logic misaligned;

  assign opcode_hit = (set_i == SET_IDENTIFY) && (op_i == OP_MEMDEV);
  assign len_bad    = (in_len_i != EXP_IN_LEN);
  assign misaligned = |cap_i[UNIT_SHIFT-1:0];

  // Priority: unknown opcode, then bad length, then misaligned capacity
  always_comb begin
    if (!opcode_hit)      status_o = RC_UNSUPPORTED;
    else if (len_bad)     status_o = RC_BAD_LEN;
    else if (misaligned)  status_o = RC_INTERNAL;
    else                  status_o = RC_OK;
  end

endmodule

// File: rtl/idmb_rsp_fields.sv
module idmb_rsp_fields
  import idmb_pkg::*;
#(
  parameter int            ADDR_W  = 8,
  parameter int            UNITS_W = 36,
  parameter logic [127:0]  FW_REV  = 128'h0
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [UNITS_W-1:0] units_i,
  output logic [7:0]         byte_o
);

  localparam int NUM_CAP_FIELDS = 2;

  logic [63:0] units64;
  assign units64 = {{(64-UNITS_W){1'b0}}, units_i};

  logic       fw_hit;
  logic [7:0] fw_byte;
  assign fw_hit  = (addr_i < ADDR_W'(OFS_FWREV + FWREV_BYTES));
  assign fw_byte = FW_REV[{addr_i[3:0], 3'b000} +: 8];

  logic [NUM_CAP_FIELDS-1:0] cap_hit;
  logic [7:0]                cap_byte [NUM_CAP_FIELDS];

  // Both capacity fields carry the same unit count at their own offsets
  for (genvar g = 0; g < NUM_CAP_FIELDS; g++) begin : g_cap
    localparam int OFS = (g == 0) ? OFS_TOTAL : OFS_PERSIST;
    logic [ADDR_W-1:0] rel;
    assign rel         = addr_i - ADDR_W'(OFS);
    assign cap_hit[g]  = (rel < ADDR_W'(CAP_FIELD_BYTES));
    assign cap_byte[g] = units64[{rel[2:0], 3'b000} +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    if (fw_hit) byte_o = fw_byte;
    for (int i = 0; i < NUM_CAP_FIELDS; i++) begin
      if (cap_hit[i]) byte_o = cap_byte[i];
    end
  end

endmodule

// File: rtl/idmb_seq.sv
module idmb_seq
  import idmb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CAP_W      = 64,
  parameter int UNIT_SHIFT = 28,
  localparam int UNITS_W   = CAP_W - UNIT_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [15:0]        status_i,
  input  logic [CAP_W-1:0]   cap_i,
  input  logic [7:0]         byte_i,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic [UNITS_W-1:0] units_o,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic               done_o,
  output logic [15:0]        ret_o,
  output logic [15:0]        len_o
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(RSP_BYTES - 1);

  seq_state_e         state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [UNITS_W-1:0] units_q;
  logic               wr_en_q;
  logic [ADDR_W-1:0]  wr_addr_q;
  logic [7:0]         wr_data_q;
  logic               done_q;
  logic [15:0]        ret_q;
  logic [15:0]        len_q;
  logic               accept;

  // Idle only once the last byte has left the write port
  assign accept = start_i && (state_q == ST_IDLE) && !wr_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      units_q   <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      done_q    <= 1'b0;
      ret_q     <= RC_OK;
      len_q     <= '0;
    end else begin
      done_q  <= 1'b0;
      wr_en_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (status_i == RC_OK) begin
              state_q <= ST_STREAM;
              addr_q  <= '0;
              units_q <= cap_i[CAP_W-1:UNIT_SHIFT];
            end else begin
              done_q <= 1'b1;
              ret_q  <= status_i;
              len_q  <= '0;
            end
          end
        end
        ST_STREAM: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= addr_q;
          wr_data_q <= byte_i;
          addr_q    <= addr_q + ADDR_W'(1);
          if (addr_q == LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (wr_en_q && (wr_addr_q == LAST)) begin
        done_q <= 1'b1;
        ret_q  <= RC_OK;
        len_q  <= 16'(RSP_BYTES);
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign units_o   = units_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign done_o    = done_q;
  assign ret_o     = ret_q;
  assign len_o     = len_q;

  AST_FIRST_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en_q) |-> (wr_addr_q == '0)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en_q && $past(wr_en_q)) |-> (wr_addr_q == $past(wr_addr_q) + ADDR_W'(1))); // R3
  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> (wr_addr_q <= LAST)); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (wr_en_q && (wr_addr_q == LAST)) |=> (done_q && (ret_q == RC_OK) && (len_q == 16'(RSP_BYTES)))); // R4
  AST_ERR_NO_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    (done_q && (ret_q != RC_OK)) |-> (!wr_en_q && (len_q == '0))); // R6
  AST_VOLATILE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en_q && (wr_addr_q >= ADDR_W'(OFS_VOLATILE)) && (wr_addr_q < ADDR_W'(OFS_PERSIST)))
      |-> (wr_data_q == 8'h00)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> ($stable(ret_q) && $stable(len_q))); // R12

endmodule

// File: rtl/idmb_identify_responder.sv
module idmb_identify_responder
  import idmb_pkg::*;
#(
  parameter int           CAP_W      = 64,
  parameter int           UNIT_SHIFT = 28,
  parameter int           ADDR_W     = 8,
  parameter logic [127:0] FW_REV     = 128'h0000_0000_0000_0000_0000_3141_2D56_4552
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [7:0]        cmd_set,
  input  logic [7:0]        cmd_op,
  input  logic [15:0]       cmd_in_len,
  input  logic [CAP_W-1:0]  dev_capacity,
  output logic              pay_we,
  output logic [ADDR_W-1:0] pay_addr,
  output logic [7:0]        pay_data,
  output logic              cmd_done,
  output logic [15:0]       cmd_rc,
  output logic [15:0]       rsp_len
);

  localparam int UNITS_W = CAP_W - UNIT_SHIFT;

  logic [15:0]        status;
  logic [ADDR_W-1:0]  rd_addr;
  logic [UNITS_W-1:0] units;
  logic [7:0]         field_byte;

  idmb_cmd_decode #(
    .CAP_W      (CAP_W),
    .UNIT_SHIFT (UNIT_SHIFT)
  ) u_decode (
    .set_i    (cmd_set),
    .op_i     (cmd_op),
    .in_len_i (cmd_in_len),
    .cap_i    (dev_capacity),
    .status_o (status)
  );

  idmb_rsp_fields #(
    .ADDR_W  (ADDR_W),
    .UNITS_W (UNITS_W),
    .FW_REV  (FW_REV)
  ) u_fields (
    .addr_i  (rd_addr),
    .units_i (units),
    .byte_o  (field_byte)
  );

  idmb_seq #(
    .ADDR_W     (ADDR_W),
    .CAP_W      (CAP_W),
    .UNIT_SHIFT (UNIT_SHIFT)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (cmd_start),
    .status_i  (status),
    .cap_i     (dev_capacity),
    .byte_i    (field_byte),
    .rd_addr_o (rd_addr),
    .units_o   (units),
    .wr_en_o   (pay_we),
    .wr_addr_o (pay_addr),
    .wr_data_o (pay_data),
    .done_o    (cmd_done),
    .ret_o     (cmd_rc),
    .len_o     (rsp_len)
  );

endmodule

// File: tb/idmb_identify_responder_tb_top.sv
`timescale 1ns/1ps
module idmb_identify_responder_tb_top;

  localparam logic [127:0] FW_EXP = 128'h0000_0000_0000_0000_0000_3141_2D56_4552;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic [7:0]  cmd_set = 8'h00;
  logic [7:0]  cmd_op = 8'h00;
  logic [15:0] cmd_in_len = 16'h0;
  logic [63:0] dev_capacity = 64'h0;
  logic        pay_we;
  logic [7:0]  pay_addr;
  logic [7:0]  pay_data;
  logic        cmd_done;
  logic [15:0] cmd_rc;
  logic [15:0] rsp_len;

  always #10 clk = ~clk;

  idmb_identify_responder dut_i (
    .clk          (clk),
    .rst          (rst),
    .cmd_start    (cmd_start),
    .cmd_set      (cmd_set),
    .cmd_op       (cmd_op),
    .cmd_in_len   (cmd_in_len),
    .dev_capacity (dev_capacity),
    .pay_we       (pay_we),
    .pay_addr     (pay_addr),
    .pay_data     (pay_data),
    .cmd_done     (cmd_done),
    .cmd_rc       (cmd_rc),
    .rsp_len      (rsp_len)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int wr_cnt, seq_err, first_cyc, done_cyc, done_cnt, st_cyc;
  logic [7:0] mem [0:255];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pay_we) begin
      if (wr_cnt == 0) first_cyc = cyc;
      if (pay_addr != 8'(wr_cnt)) seq_err++;
      mem[pay_addr] = pay_data;
      wr_cnt++;
    end
    if (cmd_done) begin
      done_cnt++;
      if (done_cyc < 0) done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int idx, input logic [63:0] units);
    if (idx < 16) return FW_EXP[8*idx +: 8];
    if (idx >= 16 && idx < 24) return units[8*(idx-16) +: 8];
    if (idx >= 32 && idx < 40) return units[8*(idx-32) +: 8];
    return 8'h00;
  endfunction

  task automatic clear_mon();
    wr_cnt = 0; seq_err = 0; first_cyc = -1; done_cyc = -1; done_cnt = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'hxx;
  endtask

  task automatic pulse(input logic [7:0] s, input logic [7:0] c, input logic [15:0] l, input logic [63:0] cap);
    @(negedge clk);
    cmd_set = s; cmd_op = c; cmd_in_len = l; dev_capacity = cap;
    cmd_start = 1'b1;
    st_cyc = cyc;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      if (done_cnt > 0) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic check_payload(input logic [63:0] cap, input string req);
    logic [63:0] units = cap >> 28;
    int mism = 0;
    for (int i = 0; i < 67; i++) if (mem[i] !== exp_byte(i, units)) mism++;
    chk(mism == 0, req, 64'(mism), 64'd0);
    chk({mem[23], mem[22], mem[21], mem[20], mem[19], mem[18], mem[17], mem[16]} === units,
        {req, " total"}, {mem[23], mem[22], mem[21], mem[20], mem[19], mem[18], mem[17], mem[16]}, units);
    chk({mem[39], mem[38], mem[37], mem[36], mem[35], mem[34], mem[33], mem[32]} === units,
        {req, " persist"}, {mem[39], mem[38], mem[37], mem[36], mem[35], mem[34], mem[33], mem[32]}, units);
  endtask

  task automatic t_reset();
    chk(cmd_done == 1'b0, "R1 done", 64'(cmd_done), 0);
    chk(pay_we == 1'b0, "R1 we", 64'(pay_we), 0);
    chk(cmd_rc == 16'h0, "R1 rc", 64'(cmd_rc), 0);
    chk(rsp_len == 16'h0, "R1 len", 64'(rsp_len), 0);
  endtask

  task automatic t_identify(input logic [63:0] cap);
    clear_mon();
    pulse(8'h40, 8'h00, 16'h0, cap);
    wait_done();
    chk(cmd_rc == 16'h0000, "R2 rc", 64'(cmd_rc), 64'h0);
    chk(rsp_len == 16'h0043, "R2 len", 64'(rsp_len), 64'h43);
    chk(wr_cnt == 67, "R3 count", 64'(wr_cnt), 64'd67);
    chk(seq_err == 0, "R3 order", 64'(seq_err), 64'd0);
    chk(first_cyc == st_cyc + 2, "R3 first", 64'(first_cyc), 64'(st_cyc + 2));
    chk(done_cyc == st_cyc + 69, "R4 done time", 64'(done_cyc), 64'(st_cyc + 69));
    chk(done_cnt == 1, "R4 single", 64'(done_cnt), 64'd1);
    check_payload(cap, "R5 payload");
  endtask

  task automatic t_error(input logic [7:0] s, input logic [7:0] c, input logic [15:0] l,
                         input logic [63:0] cap, input logic [15:0] exp_rc, input string req);
    clear_mon();
    pulse(s, c, l, cap);
    wait_done();
    chk(cmd_rc == exp_rc, {req, " rc"}, 64'(cmd_rc), 64'(exp_rc));
    chk(rsp_len == 16'h0, {req, " len"}, 64'(rsp_len), 0);
    chk(wr_cnt == 0, {req, " no write"}, 64'(wr_cnt), 0);
    chk(done_cyc == st_cyc + 1, {req, " done time"}, 64'(done_cyc), 64'(st_cyc + 1));
  endtask

  task automatic t_busy();
    logic [63:0] cap = 64'h0000_0003_0000_0000;
    clear_mon();
    pulse(8'h40, 8'h00, 16'h0, cap);
    while (cyc < st_cyc + 10) @(negedge clk);
    cmd_set = 8'h41; dev_capacity = 64'h0000_0007_1234_5678; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    while (cyc < st_cyc + 68) @(negedge clk);
    cmd_set = 8'h99; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (6) @(negedge clk);
    chk(done_cnt == 1, "R10 done count", 64'(done_cnt), 64'd1);
    chk(wr_cnt == 67, "R10 write count", 64'(wr_cnt), 64'd67);
    chk(cmd_rc == 16'h0000, "R10 rc", 64'(cmd_rc), 0);
    check_payload(cap, "R11 latched");
  endtask

  task automatic t_hold();
    logic [15:0] rc0 = cmd_rc;
    logic [15:0] ln0 = rsp_len;
    cmd_set = 8'h12; cmd_in_len = 16'h5; dev_capacity = 64'h1;
    repeat (8) @(negedge clk);
    chk(cmd_rc == rc0, "R12 rc hold", 64'(cmd_rc), 64'(rc0));
    chk(rsp_len == ln0, "R12 len hold", 64'(rsp_len), 64'(ln0));
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_identify(64'h0000_0000_1000_0000);
    t_identify(64'h0ABC_DEF1_2000_0000);
    t_identify(64'h0);
    t_hold();
    t_error(8'h40, 8'h00, 16'h0, 64'h0000_0000_1000_1000, 16'h0002, "R6 unaligned");
    t_error(8'h40, 8'h00, 16'h0, 64'h0000_0000_0000_0001, 16'h0002, "R6 low bit");
    t_error(8'h40, 8'h01, 16'h0, 64'h0000_0000_1000_0000, 16'h0015, "R7 cmd");
    t_error(8'h41, 8'h00, 16'h0, 64'h0000_0000_1000_0000, 16'h0015, "R7 set");
    t_error(8'h40, 8'h00, 16'h8, 64'h0000_0000_1000_0000, 16'h0016, "R8 length");
    t_hold();
    t_error(8'h04, 8'h00, 16'h3, 64'h0000_0000_0000_0F00, 16'h0015, "R9 unsup first");
    t_error(8'h40, 8'h00, 16'h1, 64'h0000_0000_0000_0F00, 16'h0016, "R9 len before align");
    t_busy();
    t_identify(64'h0000_0010_0000_0000);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule